// File: doc/BRIEF.md
# I2C Slave Address Matcher (7-bit and 10-bit)

This block sits behind an I2C slave's bit-level shift register and decides, one received byte at a time, whether the slave has been addressed. It takes bus events as single-cycle pulses: one for a Start or Repeated Start and one for a Stop. It takes each completed byte with a valid strobe. It compares address bytes against a configured slave address in either 7-bit or 10-bit form. It then reports an ACK/NACK decision, a write or read request pulse, and an "addressed" level.

In 10-bit mode the block follows the two-byte sequence. The first byte is a high byte carrying a fixed prefix and the two top address bits. The second byte is the low byte. After a complete write-direction match the block keeps a prior-match flag. A later Repeated Start followed by the high byte with R/W set then opens a read without the low byte being sent again. Whenever a read is accepted, the block raises a clock-hold request so SCL can be stretched while transmit data is prepared. A release pulse, a Start or a Stop drops that request. Shifting bits, driving SDA and handling data bytes belong to neighbouring logic.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While and right after reset, ack_valid, ack_ok, wr_req, rd_req, addressed, prior_match and clk_hold are all low.
- R2: In 7-bit mode, a first byte after a Start whose bits 7:1 equal own_addr[6:0] and whose bit 0 (R/W) is 0 gives ack_valid=1, ack_ok=1 and a one-cycle wr_req in the cycle after the byte, and addressed goes high.
- R3: In 7-bit mode, the same match with bit 0 = 1 gives ack_ok=1 and a one-cycle rd_req, addressed goes high, and clk_hold rises one cycle after rd_req.
- R4: A non-matching address byte gives ack_valid=1 with ack_ok=0 and leaves addressed low. Bytes that arrive after a non-match, after reset, after a Stop, or after the address phase, before the next Start, give no ack_valid.
- R5: In 10-bit mode, a first byte of 11110 followed by own_addr[9:8] and R/W=0 is ACKed without a request. If the next byte then equals own_addr[7:0], it is ACKed with wr_req, addressed goes high and prior_match goes high.
- R6: In 10-bit mode, a low byte that differs from own_addr[7:0] is NACKed, and addressed and prior_match stay low.
- R7: With prior_match high, a Repeated Start and then the high byte with R/W=1 are ACKed with rd_req, addressed goes high, prior_match stays high and clk_hold rises one cycle after rd_req.
- R8: With prior_match low, a matching high byte with R/W=1 is NACKed and addressed stays low.
- R9: prior_match is cleared by a Stop, by a matching high byte with R/W=0, and by a high byte that fails the compare. A Start or Repeated Start alone keeps it.
- R10: A Start or Repeated Start drops addressed in the next cycle and makes the next byte an address byte.
- R11: clk_hold drops in the cycle after a hold_release pulse, a Start or a Stop.
- R12: A Stop takes priority over a Start in the same cycle, and a Start takes priority over a byte strobed in the same cycle, which is then discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode10 | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_addr | input | ADDR_W (10) | Slave address; bits 6:0 are used in 7-bit mode |
| start_evt | input | 1 | One-cycle pulse on Start or Repeated Start |
| stop_evt | input | 1 | One-cycle pulse on Stop |
| byte_valid | input | 1 | rx_byte holds a completed byte this cycle |
| rx_byte | input | BYTE_W (8) | Received byte, bit 0 last on the wire |
| hold_release | input | 1 | One-cycle pulse that ends the clock hold |
| ack_valid | output | 1 | An ACK decision for an address byte is presented |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK (meaningful with ack_valid) |
| wr_req | output | 1 | One-cycle pulse: write request accepted |
| rd_req | output | 1 | One-cycle pulse: read request accepted |
| addressed | output | 1 | The slave is selected for the current transfer |
| prior_match | output | 1 | A full 10-bit write match has been recorded |
| clk_hold | output | 1 | Request to stretch SCL low |

## Verification
The bench builds the block with its default widths: a 10-bit address and 8-bit bytes. The high-byte prefix is therefore five bits and two address bits ride in it. Because the mode and the address are ports, this one build covers both 7-bit and 10-bit matching, each with its own address values. It reaches the prior-match read path, every clearing cause of the prior-match flag, and the same-cycle priority between Stop, Start and a byte strobe.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int DEF_ADDR_W = 10;
  localparam int DEF_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,   // no Start since reset or Stop
    ST_ADDR,   // next byte is the first address byte
    ST_LOW,    // 10-bit high byte matched (write), low byte expected
    ST_WR,     // addressed for writing
    ST_RD,     // addressed for reading
    ST_SKIP    // not addressed, wait for Start
  } am_state_e;
endpackage

// File: rtl/i2c_am_compare.sv
module i2c_am_compare #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              match7,
  output logic              hi_match,
  output logic              lo_match,
  output logic              rw_bit
);
  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int PFX_W = BYTE_W - 1 - HI_W;
  localparam logic [PFX_W-1:0] PFX = {{(PFX_W-1){1'b1}}, 1'b0};

  always_comb begin
    rw_bit   = rx_byte[0];
    match7   = (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
    hi_match = (rx_byte[BYTE_W-1 -: PFX_W] == PFX) &&
               (rx_byte[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
    lo_match = (rx_byte == own_addr[BYTE_W-1:0]);
  end
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode10,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic byte_valid,
  input  logic match7,
  input  logic hi_match,
  input  logic lo_match,
  input  logic rw_bit,
  output logic ack_valid,
  output logic ack_ok,
  output logic wr_req,
  output logic rd_req,
  output logic addressed,
  output logic prior_match
);
  am_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      prior_match <= 1'b0;
      ack_valid   <= 1'b0;
      ack_ok      <= 1'b0;
      wr_req      <= 1'b0;
      rd_req      <= 1'b0;
    end else begin
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      wr_req    <= 1'b0;
      rd_req    <= 1'b0;
      if (stop_evt) begin
        state       <= ST_IDLE;
        prior_match <= 1'b0;
      end else if (start_evt) begin
        state <= ST_ADDR;
      end else if (byte_valid) begin
        case (state)
          ST_ADDR: begin
            ack_valid <= 1'b1;
            if (!mode10) begin
              if (match7) begin
                ack_ok <= 1'b1;
                if (rw_bit) begin
                  rd_req <= 1'b1;
                  state  <= ST_RD;
                end else begin
                  wr_req <= 1'b1;
                  state  <= ST_WR;
                end
              end else begin
                state <= ST_SKIP;
              end
            end else if (!hi_match) begin
              prior_match <= 1'b0;
              state       <= ST_SKIP;
            end else if (!rw_bit) begin
              ack_ok      <= 1'b1;
              prior_match <= 1'b0;
              state       <= ST_LOW;
            end else if (prior_match) begin
              ack_ok <= 1'b1;
              rd_req <= 1'b1;
              state  <= ST_RD;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_LOW: begin
            ack_valid <= 1'b1;
            if (lo_match) begin
              ack_ok      <= 1'b1;
              wr_req      <= 1'b1;
              prior_match <= 1'b1;
              state       <= ST_WR;
            end else begin
              state <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addressed = (state == ST_WR) || (state == ST_RD);

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rd_req)) else $error("both requests");           // R2
  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(byte_valid)) else $error("ack w/o byte"); // R4
  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!addressed && !prior_match)) else $error("stop"); // R9
  AST_PRIOR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(prior_match) |-> wr_req) else $error("prior rise");     // R5
  AST_READ_ACKED: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (ack_valid && ack_ok)) else $error("rd nack");     // R3
endmodule

// File: rtl/i2c_am_hold.sv
module i2c_am_hold (
  input  logic clk,
  input  logic rst,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic rd_req,
  input  logic hold_release,
  output logic clk_hold
);
  always_ff @(posedge clk) begin
    if (rst)                        clk_hold <= 1'b0;
    else if (stop_evt || start_evt) clk_hold <= 1'b0;
    else if (rd_req)                clk_hold <= 1'b1;
    else if (hold_release)          clk_hold <= 1'b0;
  end

  AST_HOLD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_hold) |-> $past(rd_req)) else $error("hold rise");  // R3
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (rst)
    (stop_evt || start_evt) |=> !clk_hold) else $error("hold drop"); // R11
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode10,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              hold_release,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              wr_req,
  output logic              rd_req,
  output logic              addressed,
  output logic              prior_match,
  output logic              clk_hold
);
  logic match7, hi_match, lo_match, rw_bit;

  i2c_am_compare #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmp (
    .rx_byte(rx_byte), .own_addr(own_addr),
    .match7(match7), .hi_match(hi_match), .lo_match(lo_match), .rw_bit(rw_bit)
  );

  i2c_am_seq u_seq (
    .clk(clk), .rst(rst), .mode10(mode10),
    .start_evt(start_evt), .stop_evt(stop_evt), .byte_valid(byte_valid),
    .match7(match7), .hi_match(hi_match), .lo_match(lo_match), .rw_bit(rw_bit),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .wr_req(wr_req), .rd_req(rd_req),
    .addressed(addressed), .prior_match(prior_match)
  );

  i2c_am_hold u_hold (
    .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_req(rd_req), .hold_release(hold_release), .clk_hold(clk_hold)
  );

  AST_START_RESETS: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !stop_evt) |=> !addressed) else $error("start"); // R10
endmodule

// File: tb/test_i2c_addr_matcher.sv
module test_i2c_addr_matcher;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode10 = 1'b0;
  logic [9:0] own_addr = 10'h03A;
  logic start_evt = 1'b0, stop_evt = 1'b0, byte_valid = 1'b0, hold_release = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic ack_valid, ack_ok, wr_req, rd_req, addressed, prior_match, clk_hold;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_addr_matcher i_i2c_addr_matcher (
    .clk(clk), .rst(rst), .mode10(mode10), .own_addr(own_addr),
    .start_evt(start_evt), .stop_evt(stop_evt), .byte_valid(byte_valid),
    .rx_byte(rx_byte), .hold_release(hold_release),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .wr_req(wr_req), .rd_req(rd_req),
    .addressed(addressed), .prior_match(prior_match), .clk_hold(clk_hold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // results visible at the negedge after the strobe
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; rx_byte = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask
  task automatic do_start();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask
  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask
  task automatic do_release();
    @(negedge clk); hold_release = 1'b1;
    @(negedge clk); hold_release = 1'b0;
  endtask
  task automatic ack_is(input string tag, input logic v, input logic a);
    chk({tag, " ack_valid"}, ack_valid, v);
    chk({tag, " ack_ok"}, ack_ok, a);
  endtask

  task automatic t_reset();
    chk("R1 outputs", {ack_valid, ack_ok, wr_req, rd_req, addressed, prior_match, clk_hold}, 0);
    send_byte(8'h74);
    chk("R4 byte before start", ack_valid, 1'b0);
  endtask

  task automatic t_7bit_write();
    mode10 = 1'b0; own_addr = 10'h03A;
    do_start();
    send_byte(8'h74);
    ack_is("R2", 1'b1, 1'b1);
    chk("R2 wr_req", wr_req, 1'b1);
    chk("R2 rd_req", rd_req, 1'b0);
    chk("R2 addressed", addressed, 1'b1);
    @(negedge clk);
    chk("R2 wr_req one cycle", wr_req, 1'b0);
    send_byte(8'h74);
    chk("R4 data byte no ack", ack_valid, 1'b0);
    do_stop();
    chk("R4 stop drops addressed", addressed, 1'b0);
  endtask

  task automatic t_7bit_read();
    do_start();
    send_byte(8'h75);
    ack_is("R3", 1'b1, 1'b1);
    chk("R3 rd_req", rd_req, 1'b1);
    chk("R3 addressed", addressed, 1'b1);
    chk("R3 hold not yet", clk_hold, 1'b0);
    @(negedge clk);
    chk("R3 clk_hold", clk_hold, 1'b1);
    do_release();
    chk("R11 release", clk_hold, 1'b0);
    do_start();
    send_byte(8'h75);
    @(negedge clk);
    chk("R3 hold again", clk_hold, 1'b1);
    do_stop();
    chk("R11 stop drops hold", clk_hold, 1'b0);
  endtask

  task automatic t_7bit_miss();
    do_start();
    send_byte(8'h76);
    ack_is("R4 miss", 1'b1, 1'b0);
    chk("R4 not addressed", addressed, 1'b0);
    send_byte(8'h74);
    chk("R4 ignored after miss", ack_valid, 1'b0);
    chk("R4 still unaddressed", addressed, 1'b0);
    do_stop();
  endtask

  task automatic t_10bit_write();
    mode10 = 1'b1; own_addr = 10'h2A5;
    do_start();
    send_byte(8'hF4);
    ack_is("R5 high", 1'b1, 1'b1);
    chk("R5 no req on high", {wr_req, rd_req, addressed}, 0);
    send_byte(8'hA5);
    ack_is("R5 low", 1'b1, 1'b1);
    chk("R5 wr_req", wr_req, 1'b1);
    chk("R5 addressed", addressed, 1'b1);
    chk("R5 prior_match", prior_match, 1'b1);
  endtask

  task automatic t_10bit_prior_read();
    do_start();
    chk("R10 restart drops addressed", addressed, 1'b0);
    chk("R9 restart keeps prior", prior_match, 1'b1);
    send_byte(8'hF5);
    ack_is("R7", 1'b1, 1'b1);
    chk("R7 rd_req", rd_req, 1'b1);
    chk("R7 addressed", addressed, 1'b1);
    chk("R7 prior kept", prior_match, 1'b1);
    @(negedge clk);
    chk("R7 clk_hold", clk_hold, 1'b1);
    do_start();
    chk("R11 start drops hold", clk_hold, 1'b0);
    chk("R10 addressed low", addressed, 1'b0);
  endtask

  task automatic t_prior_clear_write_hi();
    send_byte(8'hF4);
    ack_is("R9 high write", 1'b1, 1'b1);
    chk("R9 cleared by high write", prior_match, 1'b0);
    send_byte(8'hA4);
    ack_is("R6 low miss", 1'b1, 1'b0);
    chk("R6 addressed", addressed, 1'b0);
    chk("R6 prior", prior_match, 1'b0);
  endtask

  task automatic t_read_no_prior();
    do_stop();
    do_start();
    send_byte(8'hF5);
    ack_is("R8", 1'b1, 1'b0);
    chk("R8 addressed", addressed, 1'b0);
    chk("R8 rd_req", rd_req, 1'b0);
  endtask

  task automatic t_prior_clear_fail_and_stop();
    do_start();
    send_byte(8'hF4);
    send_byte(8'hA5);
    chk("R9 prior rebuilt", prior_match, 1'b1);
    do_start();
    send_byte(8'hF6);
    ack_is("R9 high miss", 1'b1, 1'b0);
    chk("R9 cleared by failed high", prior_match, 1'b0);
    do_start();
    send_byte(8'hF4);
    send_byte(8'hA5);
    do_stop();
    chk("R9 cleared by stop", prior_match, 1'b0);
  endtask

  task automatic t_priority();
    mode10 = 1'b0; own_addr = 10'h03A;
    @(negedge clk); start_evt = 1'b1; byte_valid = 1'b1; rx_byte = 8'h74;
    @(negedge clk); start_evt = 1'b0; byte_valid = 1'b0;
    chk("R12 byte with start dropped", ack_valid, 1'b0);
    send_byte(8'h74);
    ack_is("R12 next byte is address", 1'b1, 1'b1);
    @(negedge clk); start_evt = 1'b1; stop_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0; stop_evt = 1'b0;
    chk("R12 addressed after stop+start", addressed, 1'b0);
    send_byte(8'h74);
    chk("R12 stop wins, byte ignored", ack_valid, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_7bit_write();
    t_7bit_read();
    t_7bit_miss();
    t_10bit_write();
    t_10bit_prior_read();
    t_prior_clear_write_hi();
    t_read_no_prior();
    t_prior_clear_fail_and_stop();
    t_priority();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule